// File: doc/BRIEF.md
# Three-Phase Sine-Triangle PWM Gate Generator

This block drives the six switches of a three-phase inverter bridge. One symmetric triangular carrier is shared by all three phases and compared with three sine references that sit one third of a turn apart. The references come from a 32-bit phase accumulator that steps once per carrier period and a sine table built at elaboration. Software-facing logic elsewhere supplies a tuning word that sets the output frequency, an amplitude that sets the modulation depth, a direction bit that reverses the rotation order, and a dead time in clock cycles. Each phase produces a high-side and a low-side gate command. The two are complementary apart from a dead-time gap during which both are off.

Two small state machines do the work. The carrier runs in `CAR_UP` and `CAR_DOWN`. It leaves `CAR_UP` when the count reaches the top value and leaves `CAR_DOWN` when the count reaches one, so the count visits 1..TOP..0. The cycle with count zero is the carrier bottom, and both the accumulator and the compare values update only there. Each phase has a gate sequencer with four states: `DB_IDLE` (both off, held there while disabled), `DB_HIGH`, `DB_LOW` and `DB_GAP` (both off, counting dead time). From `DB_IDLE` or from a conducting state it enters `DB_GAP` when the dead time is nonzero. When the dead time is zero it goes straight to the state that the comparison asks for. `DB_GAP` ends when its counter runs out, and the sequencer then goes to `DB_HIGH` or `DB_LOW` according to the comparison.

Top module: `spwm3_gen`

## Requirements
- R1: Phase A reads the sine table at accumulator phase plus zero. With reverse low, phase B adds 32'h55555555 and phase C adds 32'hAAAAAAAA. The table index is the top 8 bits of that sum, and entry i holds sin(2*pi*i/256) scaled to 2047.
- R2: With amplitude zero, the three high-side outputs are identical in every cycle. Each is high for TOP-1 cycles of every carrier period.
- R3: In each carrier period, a phase's compare value is c = TOP/2 + floor(floor(sine*amplitude/4096)*(TOP/2)/2048), clamped at zero. Its high-side command is on while the carrier count is below c, which is 2c-1 cycles per period when c is at least 1 and 0 cycles when c is 0.
- R4: The carrier period is 2*TOP cycles, and the count runs 1..TOP then TOP-1..0. Compare values load only on the bottom (count zero) cycle while enabled, so they stay fixed for the whole period.
- R5: The high-side and low-side outputs of a phase are never on together. With zero dead time, the low side is the exact inverse of the high side once running.
- R6: With dead time D > 0, every change from one conducting switch to the other is separated by exactly D cycles with both switches of that phase off.
- R7: While enable is low or reset is asserted, all six gate outputs are low. They are low one clock edge after enable is seen low.
- R8: The accumulator starts at zero when enabled and advances by the tuning word once per carrier period, at the bottom.
- R9: With reverse high, phases B and C exchange offsets, so phase B produces what phase C produced with reverse low, and phase C produces what phase B produced.
- R10: Amplitude scales the reference linearly from 0 to full scale (4095), as given by the formula in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the modulator; low forces all gates off and restarts carrier and accumulator |
| tune_word | input | 32 | Accumulator step per carrier period |
| amplitude | input | 12 | Modulation depth, 0 to 4095 |
| reverse | input | 1 | Exchanges the phase B and phase C references |
| dead_cycles | input | 8 | Both-off gap in clock cycles |
| gate_hi | output | 3 | High-side commands, bit 0 = phase A, bit 1 = B, bit 2 = C |
| gate_lo | output | 3 | Low-side commands, same bit order |

## Verification
The per-period pulse width is the hardest thing to observe from the ports, because each high pulse is centred on the carrier bottom and so spans two periods as seen from outside. The stimulus restarts the block through enable, which puts the carrier at a known cycle. Each measurement window then starts exactly two clock edges after enable rises and covers 2*TOP cycles, so every window belongs to one compare value. A zero tuning word freezes the references, which allows static comparison of the 120-degree spread and of the direction swap. A quarter-turn tuning word then steps phase A through 0, 90, 180 and 270 degrees over four consecutive windows.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
    localparam int NPH = 3;

    typedef enum logic {
        CAR_UP,
        CAR_DOWN
    } car_state_t;

    typedef enum logic [1:0] {
        DB_IDLE,
        DB_HIGH,
        DB_LOW,
        DB_GAP
    } db_state_t;
endpackage

// File: rtl/spwm_carrier.sv
module spwm_carrier
    import spwm_pkg::*;
#(
    parameter int CAR_TOP = 4000,
    parameter int CNT_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             bottom
);
    localparam logic [CNT_W-1:0] TOP_V = CNT_W'(CAR_TOP);
    localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

    car_state_t state;

    // state register and count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CAR_UP;
            cnt   <= '0;
        end else if (!run) begin
            state <= CAR_UP;
            cnt   <= '0;
        end else begin
            unique case (state)
                CAR_UP: begin
                    cnt <= cnt + ONE_V;
                    if (cnt + ONE_V == TOP_V) state <= CAR_DOWN;
                end
                CAR_DOWN: begin
                    cnt <= cnt - ONE_V;
                    if (cnt == ONE_V) state <= CAR_UP;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        bottom = run && (cnt == '0);
    end
endmodule

// File: rtl/spwm_phase_ref.sv
module spwm_phase_ref #(
    parameter int ACC_W   = 32,
    parameter int LUT_AW  = 8,
    parameter int SINE_W  = 12,
    parameter int AMP_W   = 12,
    parameter int CAR_TOP = 4000,
    parameter int CNT_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [ACC_W-1:0] phase,
    input  logic [ACC_W-1:0] offset,
    input  logic [AMP_W-1:0] amplitude,
    output logic [CNT_W-1:0] cmp
);
    localparam int  LUT_D = 1 << LUT_AW;
    localparam real SMAX  = real'((1 << (SINE_W - 1)) - 1);
    localparam logic [CNT_W-1:0] HALF_V = CNT_W'(CAR_TOP / 2);
    localparam int  PW = SINE_W + AMP_W + 1;
    localparam int  MW = SINE_W + CNT_W + 2;

    logic signed [SINE_W-1:0] lut [LUT_D];

    generate
        for (genvar i = 0; i < LUT_D; i++) begin : g_lut
            localparam int V = $rtoi($sin(6.283185307179586 * real'(i) / real'(LUT_D)) * SMAX);
            assign lut[i] = SINE_W'(V);
        end
    endgenerate

    logic [ACC_W-1:0]         ph_sum;
    logic [LUT_AW-1:0]        idx;
    logic signed [SINE_W-1:0] sine;
    logic signed [PW-1:0]     prod;
    logic signed [PW-1:0]     prod_sh;
    logic signed [SINE_W:0]   scaled;
    logic signed [MW-1:0]     span;
    logic signed [MW-1:0]     span_sh;
    logic signed [CNT_W+1:0]  level;
    logic [CNT_W-1:0]         cmp_next;

    always_comb begin
        ph_sum   = phase + offset;
        idx      = ph_sum[ACC_W-1 -: LUT_AW];
        sine     = lut[idx];
        prod     = sine * $signed({1'b0, amplitude});
        prod_sh  = prod >>> AMP_W;
        scaled   = prod_sh[SINE_W:0];
        span     = scaled * $signed({1'b0, HALF_V});
        span_sh  = span >>> (SINE_W - 1);
        level    = $signed({2'b00, HALF_V}) + span_sh[CNT_W+1:0];
        cmp_next = (level < 0) ? '0 : level[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmp <= HALF_V;
        else if (!run)   cmp <= HALF_V;
        else if (load)   cmp <= cmp_next;
    end
endmodule

// File: rtl/spwm_deadband.sv
module spwm_deadband
    import spwm_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            want_hi,
    input  logic [DT_W-1:0] dead,
    output logic            gate_hi,
    output logic            gate_lo
);
    localparam logic [DT_W-1:0] ONE_D = DT_W'(1);

    db_state_t       state;
    logic [DT_W-1:0] gap_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= DB_IDLE;
            gap_cnt <= '0;
        end else if (!run) begin
            state   <= DB_IDLE;
            gap_cnt <= '0;
        end else begin
            unique case (state)
                DB_IDLE: begin
                    if (dead == '0) begin
                        state <= want_hi ? DB_HIGH : DB_LOW;
                    end else begin
                        state   <= DB_GAP;
                        gap_cnt <= dead - ONE_D;
                    end
                end
                DB_HIGH: begin
                    if (!want_hi) begin
                        if (dead == '0) begin
                            state <= DB_LOW;
                        end else begin
                            state   <= DB_GAP;
                            gap_cnt <= dead - ONE_D;
                        end
                    end
                end
                DB_LOW: begin
                    if (want_hi) begin
                        if (dead == '0) begin
                            state <= DB_HIGH;
                        end else begin
                            state   <= DB_GAP;
                            gap_cnt <= dead - ONE_D;
                        end
                    end
                end
                DB_GAP: begin
                    if (gap_cnt == '0) state <= want_hi ? DB_HIGH : DB_LOW;
                    else               gap_cnt <= gap_cnt - ONE_D;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        gate_hi = 1'b0;
        gate_lo = 1'b0;
        unique case (state)
            DB_HIGH: gate_hi = 1'b1;
            DB_LOW:  gate_lo = 1'b1;
            DB_IDLE, DB_GAP: ;
        endcase
    end
endmodule

// File: rtl/spwm3_gen.sv
module spwm3_gen
    import spwm_pkg::*;
#(
    parameter int ACC_W   = 32,
    parameter int LUT_AW  = 8,
    parameter int SINE_W  = 12,
    parameter int AMP_W   = 12,
    parameter int DT_W    = 8,
    parameter int CAR_TOP = 4000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [ACC_W-1:0] tune_word,
    input  logic [AMP_W-1:0] amplitude,
    input  logic             reverse,
    input  logic [DT_W-1:0]  dead_cycles,
    output logic [NPH-1:0]   gate_hi,
    output logic [NPH-1:0]   gate_lo
);
    localparam int CNT_W = $clog2(CAR_TOP + 1);
    localparam logic [ACC_W-1:0] OFS1 = ACC_W'({1'b1, {ACC_W{1'b0}}} / 3);
    localparam logic [ACC_W-1:0] OFS2 = OFS1 + OFS1;

    logic [CNT_W-1:0]            car_cnt;
    logic                        car_bottom;
    logic [ACC_W-1:0]            acc;
    logic [NPH-1:0][CNT_W-1:0]   cmp_q;
    logic [NPH-1:0][ACC_W-1:0]   ofs;
    logic [NPH-1:0]              want_hi;

    spwm_carrier #(
        .CAR_TOP (CAR_TOP),
        .CNT_W   (CNT_W)
    ) u_carrier (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (enable),
        .cnt    (car_cnt),
        .bottom (car_bottom)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          acc <= '0;
        else if (!enable)    acc <= '0;
        else if (car_bottom) acc <= acc + tune_word;
    end

    always_comb begin
        ofs[0] = '0;
        ofs[1] = reverse ? OFS2 : OFS1;
        ofs[2] = reverse ? OFS1 : OFS2;
    end

    generate
        for (genvar p = 0; p < NPH; p++) begin : g_phase
            spwm_phase_ref #(
                .ACC_W   (ACC_W),
                .LUT_AW  (LUT_AW),
                .SINE_W  (SINE_W),
                .AMP_W   (AMP_W),
                .CAR_TOP (CAR_TOP),
                .CNT_W   (CNT_W)
            ) u_ref (
                .clk       (clk),
                .rst_n     (rst_n),
                .run       (enable),
                .load      (car_bottom),
                .phase     (acc),
                .offset    (ofs[p]),
                .amplitude (amplitude),
                .cmp       (cmp_q[p])
            );

            assign want_hi[p] = car_cnt < cmp_q[p];

            spwm_deadband #(
                .DT_W (DT_W)
            ) u_db (
                .clk     (clk),
                .rst_n   (rst_n),
                .run     (enable),
                .want_hi (want_hi[p]),
                .dead    (dead_cycles),
                .gate_hi (gate_hi[p]),
                .gate_lo (gate_lo[p])
            );
        end
    endgenerate
endmodule

// File: rtl/spwm3_gen_chk.sv
module spwm3_gen_chk #(
    parameter int NP      = 3,
    parameter int CNT_W   = 12,
    parameter int DT_W    = 8,
    parameter int CAR_TOP = 4000
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     enable,
    input logic [DT_W-1:0]          dead_cycles,
    input logic [NP-1:0]            gate_hi,
    input logic [NP-1:0]            gate_lo,
    input logic [CNT_W-1:0]         car_cnt,
    input logic [NP-1:0][CNT_W-1:0] cmp_q
);
    localparam logic [CNT_W-1:0] TOP_V = CNT_W'(CAR_TOP);

    AST_PAIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == '0);  // R5

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (gate_hi == '0 && gate_lo == '0));  // R7

    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && car_cnt != '0) |=> $stable(cmp_q));  // R4

    AST_CARRIER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        car_cnt <= TOP_V);  // R4

    AST_CARRIER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && car_cnt == '0) |=> car_cnt == CNT_W'(1));  // R4

    AST_GAP_BEFORE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dead_cycles) != '0) |-> ((gate_hi & ~$past(gate_hi) & $past(gate_lo)) == '0));  // R6
endmodule

bind spwm3_gen spwm3_gen_chk #(
    .NP      (3),
    .CNT_W   (CNT_W),
    .DT_W    (DT_W),
    .CAR_TOP (CAR_TOP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .dead_cycles (dead_cycles),
    .gate_hi     (gate_hi),
    .gate_lo     (gate_lo),
    .car_cnt     (car_cnt),
    .cmp_q       (cmp_q)
);

// File: tb/spwm3_gen_tb.sv
`timescale 1ns/1ps
module spwm3_gen_tb;
    localparam int TOP  = 100;
    localparam int HALF = TOP / 2;
    localparam int PER  = 2 * TOP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [31:0] tune = '0;
    logic [11:0] amp_i = '0;
    logic        rev = 1'b0;
    logic [7:0]  dead = '0;
    logic [2:0]  gate_hi;
    logic [2:0]  gate_lo;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spwm3_gen #(.CAR_TOP(TOP)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .tune_word   (tune),
        .amplitude   (amp_i),
        .reverse     (rev),
        .dead_cycles (dead),
        .gate_hi     (gate_hi),
        .gate_lo     (gate_lo)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected high cycles per period from the R3 formula, real arithmetic
    function automatic int exp_cnt(input int idx, input int amp);
        real s, c;
        int e;
        s = $sin(6.283185307179586 * real'(idx) / 256.0);
        c = real'(HALF) + real'(HALF) * s * real'(amp) / 4096.0;
        e = int'(2.0 * c - 1.0);
        if (e < 0) e = 0;
        return e;
    endfunction

    function automatic int idx_of(input int k, input logic [31:0] tw, input logic [31:0] off);
        logic [31:0] ph;
        ph = tw * k + off;
        return int'(ph[31:24]);
    endfunction

    function automatic bit near(input int a, input int b);
        return (a - b <= 4) && (b - a <= 4);
    endfunction

    task automatic start_run(input logic [31:0] tw, input logic [11:0] amp, input logic dir, input logic [7:0] dt);
        @(negedge clk);
        enable = 1'b0; tune = tw; amp_i = amp; rev = dir; dead = dt;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic measure_period(output int ca, output int cb, output int cc);
        ca = 0; cb = 0; cc = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            ca += int'(gate_hi[0]);
            cb += int'(gate_hi[1]);
            cc += int'(gate_hi[2]);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; enable = 1'b1;
        repeat (4) @(negedge clk);
        chk(gate_hi == 3'b0 && gate_lo == 3'b0, "R7", "gates during reset", int'({gate_hi, gate_lo}), 0);
        enable = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(gate_hi == 3'b0 && gate_lo == 3'b0, "R7", "gates disabled after reset", int'({gate_hi, gate_lo}), 0);
    endtask

    task automatic t_zero_amp();
        int ca, cb, cc, bad_eq, bad_cmp;
        start_run(32'h0100_0000, 12'd0, 1'b0, 8'd0);
        bad_eq = 0; bad_cmp = 0;
        for (int k = 0; k < 3; k++) begin
            ca = 0; cb = 0; cc = 0;
            for (int i = 0; i < PER; i++) begin
                @(negedge clk);
                ca += int'(gate_hi[0]); cb += int'(gate_hi[1]); cc += int'(gate_hi[2]);
                if (!(gate_hi[0] == gate_hi[1] && gate_hi[1] == gate_hi[2])) bad_eq++;
                if ((gate_hi ^ gate_lo) != 3'b111) bad_cmp++;
            end
            chk(ca == TOP - 1, "R2", "zero-amp phase A high cycles", ca, TOP - 1);
            chk(cb == TOP - 1 && cc == TOP - 1, "R2", "zero-amp phase B/C high cycles", cb + cc, 2 * (TOP - 1));
        end
        chk(bad_eq == 0, "R2", "cycles with unequal phases", bad_eq, 0);
        chk(bad_cmp == 0, "R5", "cycles where low side is not inverse of high", bad_cmp, 0);
    endtask

    task automatic t_static(output int sb, output int sc);
        int ca, cb, cc, ea, eb, ec;
        start_run(32'h0, 12'd4095, 1'b0, 8'd0);
        measure_period(ca, cb, cc);
        ea = exp_cnt(idx_of(0, 0, 32'h0), 4095);
        eb = exp_cnt(idx_of(0, 0, 32'h5555_5555), 4095);
        ec = exp_cnt(idx_of(0, 0, 32'hAAAA_AAAA), 4095);
        chk(near(ca, ea), "R1", "phase A width at 0 deg", ca, ea);
        chk(near(cb, eb), "R1", "phase B width at 120 deg", cb, eb);
        chk(near(cc, ec), "R3", "phase C width at 240 deg", cc, ec);
        measure_period(ca, cb, cc);
        chk(cb > ca && ca > cc, "R3", "ordering B>A>C held in next period", cb - cc, 0);
        sb = cb; sc = cc;
    endtask

    task automatic t_reverse(input int sb, input int sc);
        int ca, cb, cc;
        start_run(32'h0, 12'd4095, 1'b1, 8'd0);
        measure_period(ca, cb, cc);
        chk(cb == sc, "R9", "reversed phase B equals forward phase C", cb, sc);
        chk(cc == sb, "R9", "reversed phase C equals forward phase B", cc, sb);
    endtask

    task automatic t_amp_half();
        int ca, cb, cc, eb, ec;
        start_run(32'h0, 12'd2048, 1'b0, 8'd0);
        measure_period(ca, cb, cc);
        eb = exp_cnt(idx_of(0, 0, 32'h5555_5555), 2048);
        ec = exp_cnt(idx_of(0, 0, 32'hAAAA_AAAA), 2048);
        chk(near(cb, eb), "R10", "half amplitude phase B width", cb, eb);
        chk(near(cc, ec), "R10", "half amplitude phase C width", cc, ec);
        chk(ca == TOP - 1, "R10", "half amplitude phase A at zero angle", ca, TOP - 1);
    endtask

    task automatic t_freq();
        int ca, cb, cc, ea, ec;
        start_run(32'h4000_0000, 12'd4095, 1'b0, 8'd0);
        for (int k = 0; k < 4; k++) begin
            measure_period(ca, cb, cc);
            ea = exp_cnt(idx_of(k, 32'h4000_0000, 32'h0), 4095);
            ec = exp_cnt(idx_of(k, 32'h4000_0000, 32'hAAAA_AAAA), 4095);
            chk(near(ca, ea), "R8", $sformatf("phase A width in period %0d", k), ca, ea);
            chk(near(cc, ec), "R8", $sformatf("phase C width in period %0d", k), cc, ec);
        end
    endtask

    task automatic t_deadtime();
        int last [3];
        int gap [3];
        int both_on;
        start_run(32'h0800_0000, 12'd2048, 1'b0, 8'd5);
        both_on = 0;
        for (int p = 0; p < 3; p++) begin last[p] = 0; gap[p] = 0; end
        for (int i = 0; i < 4 * PER; i++) begin
            @(negedge clk);
            for (int p = 0; p < 3; p++) begin
                if (gate_hi[p] && gate_lo[p]) both_on++;
                else if (gate_hi[p] || gate_lo[p]) begin
                    int now;
                    now = gate_hi[p] ? 1 : 2;
                    if (last[p] != 0 && last[p] != now)
                        chk(gap[p] == 5, "R6", $sformatf("dead gap on phase %0d", p), gap[p], 5);
                    last[p] = now;
                    gap[p] = 0;
                end else begin
                    gap[p]++;
                end
            end
        end
        chk(both_on == 0, "R5", "cycles with both switches on", both_on, 0);
    endtask

    task automatic t_disable();
        start_run(32'h0800_0000, 12'd2048, 1'b0, 8'd3);
        repeat (37) @(negedge clk);
        chk(gate_hi != 3'b0 || gate_lo != 3'b0, "R7", "gates active before disable", int'({gate_hi, gate_lo}), 1);
        enable = 1'b0;
        @(negedge clk);
        chk(gate_hi == 3'b0 && gate_lo == 3'b0, "R7", "gates one edge after disable", int'({gate_hi, gate_lo}), 0);
        repeat (10) @(negedge clk);
        chk(gate_hi == 3'b0 && gate_lo == 3'b0, "R7", "gates stay off while disabled", int'({gate_hi, gate_lo}), 0);
    endtask

    initial begin
        int sb, sc;
        t_reset();
        t_zero_amp();
        t_static(sb, sc);
        t_reverse(sb, sc);
        t_amp_half();
        t_freq();
        t_deadtime();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule